// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block keeps a small, fully associative set of recent translations from virtual page number to physical frame number. A lookup is compared against every stored entry in the same cycle, and a hit returns the frame number combinationally with no access to the page tables. When nothing matches, the block reports the miss in one of two ways. In hardware refill mode it asks a table walker for the translation. In trap mode it raises a miss exception, so that a software handler can find the translation and retry the access.

The translation is installed through one of two write ports. The refill port is driven by the walker and the software write port by the handler. The block picks the entry to use. A page number that is already present is rewritten in place. Otherwise the lowest-numbered empty entry is used, and when there is none a round-robin pointer picks the victim. A flush input empties the whole buffer in a single cycle.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses (lk_hit=0, lk_pfn=0).
- R2: A lookup with lk_valid=1 is compared against all entries in the same cycle. On a match, lk_hit=1 and lk_pfn carries that entry's frame number with no clock edge in between. At most one entry matches. With no hit, lk_pfn=0.
- R3: An invalid entry never produces a hit, and lk_hit is 0 whenever lk_valid=0.
- R4: A lookup with lk_valid=1 and no hit sets walk_req=1 when trap_mode=0 and miss_trap=1 when trap_mode=1. The two are never 1 together, and both are 0 on a hit or with no lookup.
- R5: A write on the refill port (rf_valid) or the software port (sw_we) installs its page/frame pair at the clock edge, and a lookup sees it from the next cycle. When both ports write in the same cycle, the refill port wins and the software write is dropped.
- R6: Asserting flush clears every valid flag at the next edge. An install in the same cycle as flush is dropped.
- R7: An install of a new page goes to the lowest-indexed invalid entry. If all entries are valid, it goes to the entry the round-robin pointer names. The pointer is 0 after reset, is not changed by flush, and advances by one (wrapping) on every install of a new page.
- R8: An install whose page number already sits in a valid entry overwrites that entry's frame number. It creates no second copy and does not move the round-robin pointer.
- R9: A lookup in the same cycle as an install sees the contents from before that install.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_pfn | output | PFN_W | Frame number of the matching entry, 0 on miss |
| trap_mode | input | 1 | 0: misses request the walker, 1: misses raise an exception |
| walk_req | output | 1 | Miss in hardware refill mode |
| miss_trap | output | 1 | Miss in trap mode |
| rf_valid | input | 1 | Refill port write strobe |
| rf_vpn | input | VPN_W | Refill page number |
| rf_pfn | input | PFN_W | Refill frame number |
| sw_we | input | 1 | Software write strobe |
| sw_vpn | input | VPN_W | Software page number |
| sw_pfn | input | PFN_W | Software frame number |
| flush | input | 1 | Invalidate all entries |

## Verification
Three pairs of functions can land in the same cycle: an install and a flush, an install from each write port, and a lookup and an install of the page it asks for. The bench drives each pair in one cycle. For flush with install, it checks that the installed page misses after the edge. For the two ports, it checks that only the refill page hits afterwards. For the lookup, it checks that it misses before the edge and hits after it. Replacement order is judged by lookups alone: the bench fills a flushed buffer whose pointer is not at zero, and then checks which page a further install evicts.

// File: rtl/tlb_pkg.sv
// Package: shared defaults and the install-source encoding for the TLB.
// Assumes: every module of the TLB imports it; nothing here holds state.
package tlb_pkg;
    localparam int unsigned TLB_ENTRIES_DEF = 8;
    localparam int unsigned TLB_VPN_W_DEF   = 20;
    localparam int unsigned TLB_PFN_W_DEF   = 20;

    // Which write port drives an install in the current cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_WALK = 2'd1,
        SRC_SW   = 2'd2
    } fill_src_e;
endpackage

// File: rtl/tlb_match.sv
// Module: parallel tag compare of one page number against all entries.
// Assumes: valid_i marks live entries; the result is a vector with one bit per entry.
module tlb_match #(
    parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES_DEF,
    parameter int unsigned VPN_W   = tlb_pkg::TLB_VPN_W_DEF
) (
    input  logic               req_i,
    input  logic [VPN_W-1:0]   vpn_i,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [VPN_W-1:0]   tag_i [ENTRIES],
    output logic [ENTRIES-1:0] match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // One comparator per entry; an invalid entry cannot match.
        always_comb match_o[g] = req_i && valid_i[g] && (tag_i[g] == vpn_i);
    end
endmodule

// File: rtl/tlb_store.sv
// Module: entry storage (valid flag, page tag, frame) with one write port and flush.
// Assumes: flush outranks the write; wr_idx_i is in range.
module tlb_store #(
    parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES_DEF,
    parameter int unsigned VPN_W   = tlb_pkg::TLB_VPN_W_DEF,
    parameter int unsigned PFN_W   = tlb_pkg::TLB_PFN_W_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [VPN_W-1:0]   wr_vpn_i,
    input  logic [PFN_W-1:0]   wr_pfn_i,
    output logic [ENTRIES-1:0] valid_o,
    output logic [VPN_W-1:0]   vpn_o [ENTRIES],
    output logic [PFN_W-1:0]   pfn_o [ENTRIES]
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Valid flag: cleared by reset or flush, set by a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || flush_i)
                valid_o[g] <= 1'b0;
            else if (we_i && wr_idx_i == IDX_W'(g))
                valid_o[g] <= 1'b1;
        end

        // Tag and frame payload: loaded on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_o[g] <= '0;
                pfn_o[g] <= '0;
            end else if (we_i && !flush_i && wr_idx_i == IDX_W'(g)) begin
                vpn_o[g] <= wr_vpn_i;
                pfn_o[g] <= wr_pfn_i;
            end
        end
    end

    // R6: a flush leaves no valid entry behind.
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_o == '0));

    // R5: an accepted write is present at the next cycle in the chosen slot.
    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !flush_i) |=> (valid_o[$past(wr_idx_i)] &&
                                vpn_o[$past(wr_idx_i)] == $past(wr_vpn_i) &&
                                pfn_o[$past(wr_idx_i)] == $past(wr_pfn_i)));
endmodule

// File: rtl/tlb_victim.sv
// Module: chooses the slot for an install and keeps the round-robin pointer.
// Assumes: dup_i is the match vector of the install page (at most one bit set).
module tlb_victim #(
    parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_i,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] dup_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               is_dup_o
);
    logic [IDX_W-1:0] rr_ptr_q;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    // Encode the slot already holding the page, if any.
    always_comb begin
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (dup_i[i]) dup_idx = IDX_W'(i);
    end

    // Find the lowest-numbered invalid slot.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!valid_i[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
    end

    // Slot priority: existing copy, then a free slot, then the pointer.
    always_comb begin
        is_dup_o = |dup_i;
        if (is_dup_o)      idx_o = dup_idx;
        else if (any_free) idx_o = free_idx;
        else               idx_o = rr_ptr_q;
    end

    // Round-robin pointer: steps on every install of a new page.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr_q <= '0;
        else if (fire_i && !is_dup_o)
            rr_ptr_q <= (rr_ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr_q + 1'b1;
    end

    // R8: overwriting an existing page leaves the pointer alone.
    a_r8_dup_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && is_dup_o) |=> $stable(rr_ptr_q));

    // R7: a full buffer replaces the slot the pointer names.
    a_r7_full_uses_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !is_dup_o && valid_i == '1) |-> (idx_o == rr_ptr_q));

    // R7: a free slot is always taken before a live one.
    a_r7_free_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && !is_dup_o && valid_i != '1) |-> !valid_i[idx_o]);
endmodule

// File: rtl/tlb_cache.sv
// Module: fully associative translation buffer, top level.
// Purpose: combinational lookup, miss signalling to a walker or as a trap,
// two install ports (refill beats software), slot selection and flush.
// Assumes: one lookup per cycle; installs become visible one cycle later.
module tlb_cache
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES_DEF,
    parameter int unsigned VPN_W   = TLB_VPN_W_DEF,
    parameter int unsigned PFN_W   = TLB_PFN_W_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             trap_mode,
    output logic             walk_req,
    output logic             miss_trap,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PFN_W-1:0] rf_pfn,
    input  logic             sw_we,
    input  logic [VPN_W-1:0] sw_vpn,
    input  logic [PFN_W-1:0] sw_pfn,
    input  logic             flush
);
    logic [ENTRIES-1:0] ent_valid;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    fill_src_e          fill_src;
    logic [VPN_W-1:0]   fill_vpn;
    logic [PFN_W-1:0]   fill_pfn;
    logic               fill_fire;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_dup;

    // Pick the install source: the refill port outranks the software port.
    always_comb begin
        if (rf_valid)   fill_src = SRC_WALK;
        else if (sw_we) fill_src = SRC_SW;
        else            fill_src = SRC_NONE;
    end

    // Route the chosen port's data; flush cancels any install.
    always_comb begin
        case (fill_src)
            SRC_WALK: begin fill_vpn = rf_vpn; fill_pfn = rf_pfn; end
            SRC_SW:   begin fill_vpn = sw_vpn; fill_pfn = sw_pfn; end
            default:  begin fill_vpn = '0;     fill_pfn = '0;     end
        endcase
        fill_fire = (fill_src != SRC_NONE) && !flush;
    end

    tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush),
        .we_i     (fill_fire),
        .wr_idx_i (fill_idx),
        .wr_vpn_i (fill_vpn),
        .wr_pfn_i (fill_pfn),
        .valid_o  (ent_valid),
        .vpn_o    (ent_vpn),
        .pfn_o    (ent_pfn)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .req_i   (lk_valid),
        .vpn_i   (lk_vpn),
        .valid_i (ent_valid),
        .tag_i   (ent_vpn),
        .match_o (lk_match)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
        .req_i   (fill_src != SRC_NONE),
        .vpn_i   (fill_vpn),
        .valid_i (ent_valid),
        .tag_i   (ent_vpn),
        .match_o (fill_match)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fill_fire),
        .valid_i  (ent_valid),
        .dup_i    (fill_match),
        .idx_o    (fill_idx),
        .is_dup_o (fill_dup)
    );

    // Frame read-out: OR of the frames gated by the one-hot match.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (lk_match[i]) lk_pfn = lk_pfn | ent_pfn[i];
    end

    // Hit and miss reporting; the mode steers a miss to walker or trap.
    always_comb begin
        lk_hit    = |lk_match;
        walk_req  = lk_valid && !lk_hit && !trap_mode;
        miss_trap = lk_valid && !lk_hit &&  trap_mode;
    end

    // R2: the parallel compare never finds two copies of a page.
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R4: a miss goes to exactly one place and never alongside a hit.
    a_r4_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(walk_req && miss_trap) && !(lk_hit && (walk_req || miss_trap)));

    // R3: no hit without a lookup.
    a_r3_no_idle_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !lk_hit);

    // R5: an install of a new page makes one more entry valid.
    a_r5_new_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_fire && !fill_dup && ent_valid != '1) |=>
            ($countones(ent_valid) == $countones($past(ent_valid)) + 1));
endmodule

// File: tb/test_tlb_cache.sv
module test_tlb_cache;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 20;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_hit;
    logic [PW-1:0] lk_pfn;
    logic          trap_mode = 1'b0;
    logic          walk_req;
    logic          miss_trap;
    logic          rf_valid = 1'b0;
    logic [VW-1:0] rf_vpn = '0;
    logic [PW-1:0] rf_pfn = '0;
    logic          sw_we = 1'b0;
    logic [VW-1:0] sw_vpn = '0;
    logic [PW-1:0] sw_pfn = '0;
    logic          flush = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_cache i_tlb_cache (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .trap_mode(trap_mode),
        .walk_req(walk_req), .miss_trap(miss_trap), .rf_valid(rf_valid),
        .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .sw_we(sw_we), .sw_vpn(sw_vpn),
        .sw_pfn(sw_pfn), .flush(flush)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Lookup then check hit and frame (combinational, same cycle).
    task automatic look(input string req, input logic [VW-1:0] v,
                        input logic exp_hit, input logic [PW-1:0] exp_pfn);
        lk_valid = 1'b1;
        lk_vpn   = v;
        #1;
        chk(req, {31'd0, lk_hit}, {31'd0, exp_hit});
        chk(req, lk_pfn, exp_hit ? exp_pfn : '0);
        lk_valid = 1'b0;
        #1;
    endtask

    task automatic refill(input logic [VW-1:0] v, input logic [PW-1:0] p);
        rf_valid = 1'b1; rf_vpn = v; rf_pfn = p;
        tick();
        rf_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        look("R1", 20'h00000, 1'b0, '0);
        look("R1", 20'h00123, 1'b0, '0);
    endtask

    task automatic t_hit_and_modes();
        do_reset();
        trap_mode = 1'b0;
        lk_valid = 1'b1; lk_vpn = 20'h00010; #1;
        chk("R4 walk on miss", {31'd0, walk_req}, 32'd1);
        chk("R4 no trap in walk mode", {31'd0, miss_trap}, 32'd0);
        trap_mode = 1'b1; #1;
        chk("R4 trap on miss", {31'd0, miss_trap}, 32'd1);
        chk("R4 no walk in trap mode", {31'd0, walk_req}, 32'd0);
        lk_valid = 1'b0; #1;
        chk("R4 idle no trap", {31'd0, miss_trap}, 32'd0);
        sw_we = 1'b1; sw_vpn = 20'h00010; sw_pfn = 20'h0ABCD;
        tick();
        sw_we = 1'b0;
        look("R5 sw install", 20'h00010, 1'b1, 20'h0ABCD);
        lk_valid = 1'b1; lk_vpn = 20'h00010; #1;
        chk("R4 hit no trap", {31'd0, miss_trap}, 32'd0);
        lk_valid = 1'b0; #1;
        chk("R3 idle no hit", {31'd0, lk_hit}, 32'd0);
        trap_mode = 1'b0;
        refill(20'h00011, 20'h12345);
        look("R2", 20'h00011, 1'b1, 20'h12345);
        look("R2", 20'h00010, 1'b1, 20'h0ABCD);
        look("R3", 20'h00012, 1'b0, '0);
    endtask

    task automatic t_both_ports();
        do_reset();
        rf_valid = 1'b1; rf_vpn = 20'h00700; rf_pfn = 20'h00077;
        sw_we = 1'b1; sw_vpn = 20'h00701; sw_pfn = 20'h00078;
        tick();
        rf_valid = 1'b0; sw_we = 1'b0;
        look("R5 refill wins", 20'h00700, 1'b1, 20'h00077);
        look("R5 sw dropped", 20'h00701, 1'b0, '0);
    endtask

    task automatic t_flush();
        do_reset();
        refill(20'h00600, 20'h00001);
        refill(20'h00601, 20'h00002);
        flush = 1'b1;
        rf_valid = 1'b1; rf_vpn = 20'h00602; rf_pfn = 20'h00003;
        tick();
        flush = 1'b0; rf_valid = 1'b0;
        look("R6 flushed", 20'h00600, 1'b0, '0);
        look("R6 flushed", 20'h00601, 1'b0, '0);
        look("R6 install dropped", 20'h00602, 1'b0, '0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        trap_mode = 1'b0;
        lk_valid = 1'b1; lk_vpn = 20'h00800;
        rf_valid = 1'b1; rf_vpn = 20'h00800; rf_pfn = 20'h00088;
        #1;
        chk("R9 old contents", {31'd0, lk_hit}, 32'd0);
        chk("R9 miss seen", {31'd0, walk_req}, 32'd1);
        tick();
        rf_valid = 1'b0; #1;
        chk("R9 visible next cycle", {31'd0, lk_hit}, 32'd1);
        chk("R9 frame", lk_pfn, 32'h00088);
        lk_valid = 1'b0;
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int i = 0; i < 8; i++) refill(20'h00100 + 20'(i), 20'h01000 + 20'(i));
        for (int i = 0; i < 8; i++) look("R7 fill", 20'h00100 + 20'(i), 1'b1, 20'h01000 + 20'(i));
        refill(20'h00200, 20'h02000);
        look("R7 evict slot0", 20'h00100, 1'b0, '0);
        look("R7", 20'h00101, 1'b1, 20'h01001);
        look("R7", 20'h00200, 1'b1, 20'h02000);
        refill(20'h00103, 20'h0DEAD);
        look("R8 overwrite", 20'h00103, 1'b1, 20'h0DEAD);
        refill(20'h00300, 20'h03000);
        look("R8 ptr held", 20'h00101, 1'b0, '0);
        look("R8 ptr held", 20'h00102, 1'b1, 20'h01002);
        look("R8 no dup", 20'h00103, 1'b1, 20'h0DEAD);
    endtask

    task automatic t_free_first();
        do_reset();
        for (int i = 0; i < 3; i++) refill(20'h00900 + 20'(i), 20'h00009);
        flush = 1'b1; tick(); flush = 1'b0;
        for (int i = 0; i < 8; i++) refill(20'h00400 + 20'(i), 20'h04000 + 20'(i));
        refill(20'h00500, 20'h05000);
        look("R7 free first then ptr", 20'h00403, 1'b0, '0);
        look("R7", 20'h00400, 1'b1, 20'h04000);
        look("R7", 20'h00500, 1'b1, 20'h05000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_hit_and_modes();
        t_both_ports();
        t_flush();
        t_same_cycle();
        t_round_robin();
        t_free_first();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule